// File: doc/BRIEF.md
# Scaler Plane Descriptor Generator

This block turns the settings of one display plane into the stream of 32-bit descriptor words that a compositing scaler reads to fetch, scale and place that plane. The settings are the source rectangle in 16.16 fixed point, the on-screen position and size, the pixel format and component order, the line pitch, the frame base address, the line-buffer base address and the filter kernel base address. A one-cycle `start` latches all settings. The block then picks a scaling mode for each axis on its own. A destination larger than the source selects polyphase, a smaller one selects trapezoidal, and an equal one selects none.

The number of words in the stream depends on those two modes. Every word leaves on a valid/ready port together with its word offset inside the descriptor. Scale factors and reciprocals come from a single multi-cycle divider, and the stream stalls while a division runs. The control word sits at offset 0, but it leaves last, because its size field can only be filled in once the length is known. The block also reports the line-buffer size that the plane needs. A request the scaler cannot serve raises `error` and produces no words.

Top module: `scl_plane_desc_gen`

## Requirements
- R1: Each axis selects polyphase when the destination is larger than the integer source size, trapezoidal when it is smaller, and none when they are equal. The plane is unity when both axes are none. A 3-bit code goes into both control word fields [7:5] and [10:8]. The code is 0 for H poly/V poly, 1 for H trap/V poly, 2 for H poly/V trap, 3 for H trap/V trap, 4 for H poly/V none, 5 for H none/V poly, 6 for H none/V trap, 7 for H trap/V none, and 0 under unity.
- R2: The control word has offset 0 and is the last word emitted. Its fields are [31]=1, [29:24]=the total word count including itself, [14:13]=component order, [4]=unity, and [3:0]=pixel format. `done` rises the cycle after the control word is accepted. All other words carry offsets 1, 2, 3 and so on, in emission order.
- R3: Four fixed words always come first. They are the position word (x at [15:0], y at [31:16]), the source size word (integer width at [15:0], integer height at [31:16]), the frame base address, and the pitch at [15:0]. When the plane is not unity, a scaled size word (destination width at [15:0], height at [31:16]) is placed between the position word and the source size word.
- R4: When the plane is not unity, the following words come after the pitch, in this order: the line-buffer base address (only when the vertical mode is not none), the horizontal polyphase word, the vertical polyphase word with a context word 0xC0C0C0C0, the horizontal trapezoidal pair, the vertical trapezoidal pair with a context word 0xC0C0C0C0, and then the kernel words. Each item appears only when its axis uses that mode.
- R5: A polyphase word has bit 30 set and the scale (src<<16)/dst in bits [24:8]. All other bits are 0.
- R6: A trapezoidal pair is made of two words. The first holds the scale (src<<16)/dst in bits [28:8]. The second holds 0xFFFFFFFF divided by that full 32-bit scale, in bits [15:0]. All other bits of both words are 0.
- R7: When either axis is polyphase, four words follow, each holding the kernel base in [13:0].
- R8: `lbm_size` is 0 under unity. Otherwise it is the larger of the integer source width and the destination width, times 8 when the vertical mode is trapezoidal or times 16 in all other cases, rounded up to a multiple of 32.
- R9: A request is rejected when any of the four source values has nonzero bits [15:0], when a cursor plane is not unity, or when the destination width or height is 0. A rejected request sets `error` and `done` two cycles after `start` and emits no word.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` and `out_index` hold their values. A `start` that arrives while a request is in progress is ignored.
- R11: After reset, `out_valid`, `done` and `error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Latch settings and begin one request |
| src_x | input | 32 | Source x, 16.16 |
| src_y | input | 32 | Source y, 16.16 |
| src_w | input | 32 | Source width, 16.16 |
| src_h | input | 32 | Source height, 16.16 |
| dst_x | input | 12 | On-screen x |
| dst_y | input | 12 | On-screen y |
| dst_w | input | 12 | On-screen width |
| dst_h | input | 12 | On-screen height |
| pix_fmt | input | 4 | Pixel format code |
| pix_order | input | 2 | Component order code |
| is_cursor | input | 1 | Plane is a cursor plane |
| fb_base | input | 32 | Frame base address |
| pitch | input | 16 | Line pitch in bytes |
| lbm_base | input | 32 | Line-buffer base address |
| kernel_base | input | 14 | Filter kernel base address |
| out_valid | output | 1 | Descriptor word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 32 | Descriptor word |
| out_index | output | 5 | Word offset inside the descriptor |
| done | output | 1 | Request finished, held until next start |
| error | output | 1 | Request rejected, held until next start |
| lbm_size | output | 21 | Line-buffer bytes needed |

## Verification
Directed requests cover all nine combinations of horizontal and vertical mode. From the word count and the offsets of the scaling words alone, each combination can be told apart from the others. Requests that set fractional bits, mark a scaled plane as cursor, or give a zero destination must leave the stream silent. A cursor that is not scaled must still pass. Random sizes with a random ready pattern test the divider results at many ratios. They also show that back-pressure neither reorders nor changes any word. In one request, a second `start` is sent mid-stream with different settings. If the block restarted, the stream would no longer match the first request.

// File: rtl/scl_desc_pkg.sv
// Shared types for the plane descriptor generator.
// Assumes 32-bit descriptor words and 16.16 source coordinates.
package scl_desc_pkg;

    localparam int WORD_W = 32;
    localparam int FRAC_W = 16;
    localparam logic [WORD_W-1:0] CTX_WORD = 32'hC0C0C0C0;

    // Scaling mode of one axis
    typedef enum logic [1:0] {
        AX_NONE = 2'd0,
        AX_POLY = 2'd1,
        AX_TRAP = 2'd2
    } axis_mode_e;

    // Descriptor steps in emission order; the control word goes last
    typedef enum logic [4:0] {
        ST_POS0, ST_SCLDIM, ST_SRCSZ, ST_BASE, ST_PITCH, ST_LBUF,
        ST_HPOLY, ST_VPOLY, ST_VPOLY_CTX, ST_HTRAP_S, ST_HTRAP_R,
        ST_VTRAP_S, ST_VTRAP_R, ST_VTRAP_CTX,
        ST_KER0, ST_KER1, ST_KER2, ST_KER3, ST_CTRL
    } step_e;

    // Pack two 16-bit values into one word: first at [15:0], second at [31:16]
    function automatic logic [WORD_W-1:0] pair_word(input logic [15:0] lo,
                                                    input logic [15:0] hi);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/scl_mode_sel.sv
// Per-axis scaling mode selection, scaling code and line-buffer size.
// Purely combinational. Assumes DIM_W <= SRC_INT_W.
module scl_mode_sel
    import scl_desc_pkg::*;
#(
    parameter int SRC_INT_W = 16,
    parameter int DIM_W     = 12,
    parameter int LBUF_W    = SRC_INT_W + 5
) (
    input  logic [SRC_INT_W-1:0] src_w_i,
    input  logic [SRC_INT_W-1:0] src_h_i,
    input  logic [DIM_W-1:0]     dst_w_i,
    input  logic [DIM_W-1:0]     dst_h_i,
    output axis_mode_e           h_mode,
    output axis_mode_e           v_mode,
    output logic                 unity,
    output logic [2:0]           scl_code,
    output logic [LBUF_W-1:0]    lbuf_size
);

    localparam logic [LBUF_W-1:0] ALIGN_M = LBUF_W'(31);

    logic [SRC_INT_W-1:0] dw_ext, dh_ext, widest;
    logic [LBUF_W-1:0]    lbuf_raw;

    // Compare one axis: grow, shrink or keep
    function automatic axis_mode_e pick(input logic [SRC_INT_W-1:0] s,
                                        input logic [SRC_INT_W-1:0] d);
        if (d > s)      return AX_POLY;
        else if (d < s) return AX_TRAP;
        else            return AX_NONE;
    endfunction

    // Mode per axis and the unity flag
    always_comb begin
        dw_ext = SRC_INT_W'(dst_w_i);
        dh_ext = SRC_INT_W'(dst_h_i);
        h_mode = pick(src_w_i, dw_ext);
        v_mode = pick(src_h_i, dh_ext);
        unity  = (h_mode == AX_NONE) && (v_mode == AX_NONE);
    end

    // Map the mode pair to the 3-bit scaling code
    always_comb begin
        case ({h_mode, v_mode})
            {AX_POLY, AX_POLY}: scl_code = 3'd0;
            {AX_TRAP, AX_POLY}: scl_code = 3'd1;
            {AX_POLY, AX_TRAP}: scl_code = 3'd2;
            {AX_TRAP, AX_TRAP}: scl_code = 3'd3;
            {AX_POLY, AX_NONE}: scl_code = 3'd4;
            {AX_NONE, AX_POLY}: scl_code = 3'd5;
            {AX_NONE, AX_TRAP}: scl_code = 3'd6;
            {AX_TRAP, AX_NONE}: scl_code = 3'd7;
            default:            scl_code = 3'd0;
        endcase
    end

    // Line-buffer bytes: widest line times 8 or 16, aligned up to 32
    always_comb begin
        widest   = (src_w_i > dw_ext) ? src_w_i : dw_ext;
        lbuf_raw = (v_mode == AX_TRAP) ? (LBUF_W'(widest) << 3)
                                       : (LBUF_W'(widest) << 4);
        lbuf_size = unity ? '0 : ((lbuf_raw + ALIGN_M) & ~ALIGN_M);
    end

endmodule

// File: rtl/scl_seq_div.sv
// Restoring unsigned divider, one quotient bit per cycle, W cycles.
// Assumes den is nonzero; go is only raised while not busy.
module scl_seq_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo
);

    localparam int CNT_W = $clog2(W + 1);

    logic [W:0]       rem_q;
    logic [W-1:0]     den_q, num_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W:0]       trial;

    assign trial = {rem_q[W-1:0], quo[W-1]};

    // Shift-subtract iteration and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            den_q <= '0;
            num_q <= '0;
            quo   <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                rem_q <= '0;
                quo   <= num;
                num_q <= num;
                den_q <= den;
                cnt_q <= CNT_W'(W);
                busy  <= 1'b1;
            end else if (busy) begin
                if (trial >= {1'b0, den_q}) begin
                    rem_q <= trial - {1'b0, den_q};
                    quo   <= {quo[W-2:0], 1'b1};
                end else begin
                    rem_q <= trial;
                    quo   <= {quo[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // The quotient is exact: q*d <= n < (q+1)*d (scale values, R5 and R6)
    p_div_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((2*W)'(quo) * (2*W)'(den_q) <= (2*W)'(num_q)) &&
                 (((2*W)'(quo) + 1) * (2*W)'(den_q) > (2*W)'(num_q)));

endmodule

// File: rtl/scl_plane_desc_gen.sv
// Plane descriptor generator: latches plane settings on start, checks them,
// then emits descriptor words with their offsets on a valid/ready port.
// The control word (offset 0) is emitted last with the final word count.
// Assumes a single outstanding request; start is ignored while busy.
module scl_plane_desc_gen
    import scl_desc_pkg::*;
#(
    parameter int DIM_W     = 12,
    parameter int SRC_INT_W = 16,
    parameter int ADDR_W    = 32,
    parameter int PITCH_W   = 16,
    parameter int KER_W     = 14,
    parameter int FMT_W     = 4,
    parameter int IDX_W     = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [SRC_INT_W+FRAC_W-1:0]   src_x,
    input  logic [SRC_INT_W+FRAC_W-1:0]   src_y,
    input  logic [SRC_INT_W+FRAC_W-1:0]   src_w,
    input  logic [SRC_INT_W+FRAC_W-1:0]   src_h,
    input  logic [DIM_W-1:0]              dst_x,
    input  logic [DIM_W-1:0]              dst_y,
    input  logic [DIM_W-1:0]              dst_w,
    input  logic [DIM_W-1:0]              dst_h,
    input  logic [FMT_W-1:0]              pix_fmt,
    input  logic [1:0]                    pix_order,
    input  logic                          is_cursor,
    input  logic [ADDR_W-1:0]             fb_base,
    input  logic [PITCH_W-1:0]            pitch,
    input  logic [ADDR_W-1:0]             lbm_base,
    input  logic [KER_W-1:0]              kernel_base,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [WORD_W-1:0]             out_data,
    output logic [IDX_W-1:0]              out_index,
    output logic                          done,
    output logic                          error,
    output logic [SRC_INT_W+4:0]          lbm_size
);

    localparam int SRC_W  = SRC_INT_W + FRAC_W;
    localparam int LBUF_W = SRC_INT_W + 5;

    typedef enum logic [1:0] {PH_IDLE, PH_CHECK, PH_RUN} phase_e;

    phase_e              phase_q;
    step_e               step_q;
    logic [IDX_W-1:0]    idx_q;
    logic                have_q, wait_q;
    logic [WORD_W-1:0]   quo_q, scale_q;

    // Latched settings
    logic [SRC_W-1:0]    c_sx, c_sy, c_sw, c_sh;
    logic [DIM_W-1:0]    c_dx, c_dy, c_dw, c_dh;
    logic [FMT_W-1:0]    c_fmt;
    logic [1:0]          c_ord;
    logic                c_cur;
    logic [ADDR_W-1:0]   c_fb, c_lb;
    logic [PITCH_W-1:0]  c_pitch;
    logic [KER_W-1:0]    c_ker;

    axis_mode_e          h_mode, v_mode;
    logic                unity;
    logic [2:0]          scl_code;
    logic [LBUF_W-1:0]   lbuf;

    logic                present, needs_div, any_poly, reject;
    logic                div_go, div_busy, div_done;
    logic [WORD_W-1:0]   div_num, div_den, div_quo;
    logic [WORD_W-1:0]   ctrl_word, word;

    scl_mode_sel #(
        .SRC_INT_W (SRC_INT_W),
        .DIM_W     (DIM_W),
        .LBUF_W    (LBUF_W)
    ) u_mode (
        .src_w_i   (c_sw[SRC_W-1:FRAC_W]),
        .src_h_i   (c_sh[SRC_W-1:FRAC_W]),
        .dst_w_i   (c_dw),
        .dst_h_i   (c_dh),
        .h_mode    (h_mode),
        .v_mode    (v_mode),
        .unity     (unity),
        .scl_code  (scl_code),
        .lbuf_size (lbuf)
    );

    scl_seq_div #(.W(WORD_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (div_num),
        .den   (div_den),
        .busy  (div_busy),
        .done  (div_done),
        .quo   (div_quo)
    );

    assign lbm_size = lbuf;
    assign any_poly = (h_mode == AX_POLY) || (v_mode == AX_POLY);

    // Rejection rules evaluated on the latched settings
    assign reject = (|c_sx[FRAC_W-1:0]) || (|c_sy[FRAC_W-1:0]) ||
                    (|c_sw[FRAC_W-1:0]) || (|c_sh[FRAC_W-1:0]) ||
                    (c_cur && !unity) || (c_dw == '0) || (c_dh == '0);

    // Whether the current step contributes a word for these modes
    always_comb begin
        case (step_q)
            ST_SCLDIM:                         present = !unity;
            ST_LBUF:                           present = !unity && (v_mode != AX_NONE);
            ST_HPOLY:                          present = (h_mode == AX_POLY);
            ST_VPOLY, ST_VPOLY_CTX:            present = (v_mode == AX_POLY);
            ST_HTRAP_S, ST_HTRAP_R:            present = (h_mode == AX_TRAP);
            ST_VTRAP_S, ST_VTRAP_R,
            ST_VTRAP_CTX:                      present = (v_mode == AX_TRAP);
            ST_KER0, ST_KER1, ST_KER2, ST_KER3: present = any_poly;
            default:                           present = 1'b1;
        endcase
    end

    // Division operands for the steps that carry a quotient
    always_comb begin
        needs_div = 1'b1;
        div_num   = '0;
        div_den   = WORD_W'(1);
        case (step_q)
            ST_HPOLY, ST_HTRAP_S: begin
                div_num = {c_sw[SRC_W-1:FRAC_W], {FRAC_W{1'b0}}};
                div_den = WORD_W'(c_dw);
            end
            ST_VPOLY, ST_VTRAP_S: begin
                div_num = {c_sh[SRC_W-1:FRAC_W], {FRAC_W{1'b0}}};
                div_den = WORD_W'(c_dh);
            end
            ST_HTRAP_R, ST_VTRAP_R: begin
                div_num = '1;
                div_den = scale_q;
            end
            default: needs_div = 1'b0;
        endcase
    end

    assign div_go    = (phase_q == PH_RUN) && present && needs_div && !have_q && !wait_q;
    assign out_valid = (phase_q == PH_RUN) && present && (!needs_div || have_q);
    assign out_index = (step_q == ST_CTRL) ? '0 : idx_q;

    // Control word with the size field taken from the running count
    always_comb begin
        ctrl_word        = '0;
        ctrl_word[31]    = 1'b1;
        ctrl_word[29:24] = 6'(idx_q);
        ctrl_word[14:13] = c_ord;
        ctrl_word[10:8]  = scl_code;
        ctrl_word[7:5]   = scl_code;
        ctrl_word[4]     = unity;
        ctrl_word[3:0]   = 4'(c_fmt);
    end

    // Word contents per step
    always_comb begin
        word = '0;
        case (step_q)
            ST_POS0:   word = pair_word(16'(c_dx), 16'(c_dy));
            ST_SCLDIM: word = pair_word(16'(c_dw), 16'(c_dh));
            ST_SRCSZ:  word = pair_word(16'(c_sw[SRC_W-1:FRAC_W]), 16'(c_sh[SRC_W-1:FRAC_W]));
            ST_BASE:   word = WORD_W'(c_fb);
            ST_PITCH:  word = WORD_W'(c_pitch);
            ST_LBUF:   word = WORD_W'(c_lb);
            ST_HPOLY, ST_VPOLY: begin
                word[30]   = 1'b1;
                word[24:8] = quo_q[16:0];
            end
            ST_HTRAP_S, ST_VTRAP_S: word[28:8] = quo_q[20:0];
            ST_HTRAP_R, ST_VTRAP_R: word[15:0] = quo_q[15:0];
            ST_VPOLY_CTX, ST_VTRAP_CTX: word = CTX_WORD;
            ST_KER0, ST_KER1, ST_KER2, ST_KER3: word = WORD_W'(c_ker);
            ST_CTRL:   word = ctrl_word;
            default:   word = '0;
        endcase
    end
    assign out_data = word;

    // Request sequencing: latch, check, then walk the steps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            step_q  <= ST_POS0;
            idx_q   <= IDX_W'(1);
            have_q  <= 1'b0;
            wait_q  <= 1'b0;
            quo_q   <= '0;
            scale_q <= '0;
            done    <= 1'b0;
            error   <= 1'b0;
            c_sx <= '0; c_sy <= '0; c_sw <= '0; c_sh <= '0;
            c_dx <= '0; c_dy <= '0; c_dw <= '0; c_dh <= '0;
            c_fmt <= '0; c_ord <= '0; c_cur <= 1'b0;
            c_fb <= '0; c_lb <= '0; c_pitch <= '0; c_ker <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        c_sx <= src_x; c_sy <= src_y; c_sw <= src_w; c_sh <= src_h;
                        c_dx <= dst_x; c_dy <= dst_y; c_dw <= dst_w; c_dh <= dst_h;
                        c_fmt <= pix_fmt; c_ord <= pix_order; c_cur <= is_cursor;
                        c_fb <= fb_base; c_lb <= lbm_base; c_pitch <= pitch;
                        c_ker <= kernel_base;
                        done    <= 1'b0;
                        error   <= 1'b0;
                        phase_q <= PH_CHECK;
                    end
                end
                PH_CHECK: begin
                    if (reject) begin
                        error   <= 1'b1;
                        done    <= 1'b1;
                        phase_q <= PH_IDLE;
                    end else begin
                        step_q  <= ST_POS0;
                        idx_q   <= IDX_W'(1);
                        have_q  <= 1'b0;
                        wait_q  <= 1'b0;
                        phase_q <= PH_RUN;
                    end
                end
                PH_RUN: begin
                    if (div_go) wait_q <= 1'b1;
                    if (div_done) begin
                        quo_q  <= div_quo;
                        have_q <= 1'b1;
                        wait_q <= 1'b0;
                    end
                    if (!present) begin
                        step_q <= step_e'(step_q + 5'd1);
                    end else if (out_valid && out_ready) begin
                        have_q <= 1'b0;
                        if (step_q == ST_HTRAP_S || step_q == ST_VTRAP_S)
                            scale_q <= quo_q;
                        if (step_q == ST_CTRL) begin
                            done    <= 1'b1;
                            phase_q <= PH_IDLE;
                        end else begin
                            idx_q  <= idx_q + 1'b1;
                            step_q <= step_e'(step_q + 5'd1);
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Stalled words stay put (R10)
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_index));

    // A rejected request never drives the stream (R9)
    p_silent_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !out_valid);

    // Accepting offset 0 ends the request (R2)
    p_ctrl_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && (out_index == '0) |=> done && !out_valid);

    // The divider is never restarted mid-division (R6)
    p_div_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        div_go |-> !div_busy);

    // Line-buffer size aligned and at least eight bytes per output pixel (R8)
    p_lbuf_bounds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RUN) && !unity |->
            (lbuf[4:0] == 5'd0) && (lbuf >= (LBUF_W'(c_dw) << 3)));

endmodule

// File: tb/tb_scl_plane_desc_gen.sv
`timescale 1ns/1ps
module tb_scl_plane_desc_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src_x = '0, src_y = '0, src_w = '0, src_h = '0;
    logic [11:0] dst_x = '0, dst_y = '0, dst_w = '0, dst_h = '0;
    logic [3:0]  pix_fmt = '0;
    logic [1:0]  pix_order = '0;
    logic        is_cursor = 1'b0;
    logic [31:0] fb_base = '0;
    logic [15:0] pitch = '0;
    logic [31:0] lbm_base = '0;
    logic [13:0] kernel_base = '0;
    logic        out_valid, out_ready = 1'b0;
    logic [31:0] out_data;
    logic [4:0]  out_index;
    logic        done, error;
    logic [20:0] lbm_size;

    scl_plane_desc_gen dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_x(src_x), .src_y(src_y), .src_w(src_w), .src_h(src_h),
        .dst_x(dst_x), .dst_y(dst_y), .dst_w(dst_w), .dst_h(dst_h),
        .pix_fmt(pix_fmt), .pix_order(pix_order), .is_cursor(is_cursor),
        .fb_base(fb_base), .pitch(pitch), .lbm_base(lbm_base),
        .kernel_base(kernel_base), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_index(out_index), .done(done), .error(error),
        .lbm_size(lbm_size)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int failures = 0;

    logic [31:0] exp_w [0:23];
    logic [4:0]  exp_i [0:23];
    string       exp_r [0:23];
    int          exp_n;
    logic        exp_err;
    logic [20:0] exp_lb;

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // 0 none, 1 polyphase, 2 trapezoidal (R1)
    function automatic int mode_of(input int unsigned s, input int unsigned d);
        if (d > s) return 1;
        if (d < s) return 2;
        return 0;
    endfunction

    function automatic logic [2:0] code_of(input int h, input int v);
        if (h == 1 && v == 1) return 3'd0;
        if (h == 2 && v == 1) return 3'd1;
        if (h == 1 && v == 2) return 3'd2;
        if (h == 2 && v == 2) return 3'd3;
        if (h == 1 && v == 0) return 3'd4;
        if (h == 0 && v == 1) return 3'd5;
        if (h == 0 && v == 2) return 3'd6;
        if (h == 2 && v == 0) return 3'd7;
        return 3'd0;
    endfunction

    task automatic push(input logic [31:0] w, input string r);
        exp_w[exp_n] = w;
        exp_i[exp_n] = 5'(exp_n + 1);
        exp_r[exp_n] = r;
        exp_n++;
    endtask

    // Reference model of the descriptor built from the requirements
    task automatic build_expected();
        int unsigned sw, sh, dw, dh, wide, m;
        int h, v;
        logic unity;
        logic [31:0] sc, ctl;
        logic [2:0] code;
        sw = src_w[31:16]; sh = src_h[31:16];
        dw = dst_w; dh = dst_h;
        h = mode_of(sw, dw); v = mode_of(sh, dh);
        unity = (h == 0 && v == 0);
        exp_n = 0;
        exp_err = (src_x[15:0] != 0) || (src_y[15:0] != 0) || (src_w[15:0] != 0) ||
                  (src_h[15:0] != 0) || (is_cursor && !unity) || dw == 0 || dh == 0;
        wide = (sw > dw) ? sw : dw;
        m = (v == 2) ? wide * 8 : wide * 16;
        exp_lb = unity ? 21'd0 : 21'(((m + 31) / 32) * 32);
        if (exp_err) return;
        push({4'b0, dst_y, 4'b0, dst_x}, "R3");
        if (!unity) push({4'b0, dst_h, 4'b0, dst_w}, "R3");
        push({src_h[31:16], src_w[31:16]}, "R3");
        push(fb_base, "R3");
        push({16'b0, pitch}, "R3");
        if (!unity && v != 0) push(lbm_base, "R4");
        if (h == 1) begin
            sc = 32'((64'(sw) << 16) / dw);
            push(32'h4000_0000 | ((sc & 32'h1FFFF) << 8), "R5");
        end
        if (v == 1) begin
            sc = 32'((64'(sh) << 16) / dh);
            push(32'h4000_0000 | ((sc & 32'h1FFFF) << 8), "R5");
            push(32'hC0C0C0C0, "R4");
        end
        if (h == 2) begin
            sc = 32'((64'(sw) << 16) / dw);
            push((sc & 32'h1FFFFF) << 8, "R6");
            push((32'hFFFFFFFF / sc) & 32'hFFFF, "R6");
        end
        if (v == 2) begin
            sc = 32'((64'(sh) << 16) / dh);
            push((sc & 32'h1FFFFF) << 8, "R6");
            push((32'hFFFFFFFF / sc) & 32'hFFFF, "R6");
            push(32'hC0C0C0C0, "R4");
        end
        if (h == 1 || v == 1)
            for (int k = 0; k < 4; k++) push({18'b0, kernel_base}, "R7");
        code = code_of(h, v);
        ctl = 32'h8000_0000 | (32'(exp_n + 1) << 24) | (32'(pix_order) << 13) |
              (32'(code) << 8) | (32'(code) << 5) | (32'(unity) << 4) | 32'(pix_fmt);
        exp_w[exp_n] = ctl;
        exp_i[exp_n] = 5'd0;
        exp_r[exp_n] = "R1/R2";
        exp_n++;
    endtask

    task automatic set_plane(input int sw, input int sh, input int dw, input int dh);
        src_x = 32'(($urandom % 200)) << 16;
        src_y = 32'(($urandom % 200)) << 16;
        src_w = 32'(sw) << 16;
        src_h = 32'(sh) << 16;
        dst_x = 12'($urandom);
        dst_y = 12'($urandom);
        dst_w = 12'(dw);
        dst_h = 12'(dh);
        pix_fmt = 4'($urandom);
        pix_order = 2'($urandom);
        fb_base = $urandom;
        pitch = 16'($urandom);
        lbm_base = $urandom;
        kernel_base = 14'($urandom);
        is_cursor = 1'b0;
    endtask

    // Issue one request and compare the stream word by word
    task automatic run_case(input string name, input bit poke_busy);
        int got;
        int cyc;
        build_expected();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = 0;
        cyc = 0;
        while (!done && cyc < 3000) begin
            out_ready = ($urandom % 4) != 0;
            if (poke_busy && cyc == 3) begin
                start = 1'b1;
                src_w = src_w + 32'h0001_0000;
            end else begin
                start = 1'b0;
            end
            if (out_valid && out_ready) begin
                if (got < exp_n) begin
                    chk(exp_r[got], out_data, exp_w[got], {name, " word"});
                    chk("R2", 32'(out_index), 32'(exp_i[got]), {name, " offset"});
                end else begin
                    chk("R9", 32'(out_index), 32'hFFFF_FFFF, {name, " extra word"});
                end
                got++;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        out_ready = 1'b0;
        chk("R2", 32'(done), 32'd1, {name, " done reached"});
        chk(exp_err ? "R9" : "R2", 32'(got), 32'(exp_n), {name, " word count"});
        chk("R9", 32'(error), 32'(exp_err), {name, " error flag"});
        if (!exp_err) chk("R8", 32'(lbm_size), 32'(exp_lb), {name, " line buffer size"});
        if (poke_busy) chk("R10", 32'(got), 32'(exp_n), {name, " start while busy"});
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11", 32'(out_valid), 32'd0, "out_valid after reset");
        chk("R11", 32'(done), 32'd0, "done after reset");
        chk("R11", 32'(error), 32'd0, "error after reset");

        // R1: all nine mode pairs
        set_plane(100, 80, 100, 80);  run_case("unity", 1'b0);
        set_plane(100, 80, 150, 120); run_case("hpoly_vpoly", 1'b0);
        set_plane(100, 80, 50, 120);  run_case("htrap_vpoly", 1'b0);
        set_plane(100, 80, 150, 40);  run_case("hpoly_vtrap", 1'b0);
        set_plane(100, 80, 33, 17);   run_case("htrap_vtrap", 1'b0);
        set_plane(100, 80, 150, 80);  run_case("hpoly_vnone", 1'b0);
        set_plane(100, 80, 100, 120); run_case("hnone_vpoly", 1'b0);
        set_plane(100, 80, 100, 7);   run_case("hnone_vtrap", 1'b0);
        set_plane(100, 80, 9, 80);    run_case("htrap_vnone", 1'b0);
        // R6: extreme ratios
        set_plane(4095, 4095, 1, 1);  run_case("max_shrink", 1'b0);
        set_plane(1, 1, 4095, 4095);  run_case("max_grow", 1'b0);

        // R9: rejections
        set_plane(64, 64, 64, 64); src_x = src_x | 32'h1; run_case("frac_x", 1'b0);
        set_plane(64, 64, 32, 64); src_h = src_h | 32'h8000; run_case("frac_h", 1'b0);
        set_plane(64, 64, 32, 64); is_cursor = 1'b1; run_case("cursor_scaled", 1'b0);
        set_plane(64, 64, 64, 64); is_cursor = 1'b1; run_case("cursor_unity", 1'b0);
        set_plane(64, 64, 0, 64);  run_case("zero_width", 1'b0);

        // R10: start during a request is ignored
        set_plane(90, 70, 30, 140); run_case("busy_start", 1'b1);

        // Random sizes under random back-pressure
        for (int n = 0; n < 60; n++) begin
            int sw, sh, dw, dh;
            sw = 1 + int'($urandom % 400);
            sh = 1 + int'($urandom % 400);
            dw = ($urandom % 4 == 0) ? sw : 1 + int'($urandom % 400);
            dh = ($urandom % 4 == 0) ? sh : 1 + int'($urandom % 400);
            set_plane(sw, sh, dw, dh);
            run_case("random", 1'b0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule